// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block protects a system against runaway software. An 8-bit down counter is advanced by a programmable prescaler. The prescaler is clocked by one of two sources: ticks from a dedicated low-speed oscillator, or the bus clock divided by 32. When the counter passes zero, the result depends on the mode. In reset mode the block raises a sticky system-reset request. In interval mode it sets a timeout flag and, if enabled, an interrupt.

Software never writes the live counter or the live control directly. It writes a staging control byte and a staging reload byte, then performs a two-write key sequence. The staged values move into the live counter and the shadow control on the next tick of the currently selected counting clock. In interval mode the shadow control follows the staging control on every bus-clock cycle without any key. Even in that mode, reloading the counter still needs the key sequence.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `rst_req`, `tmo_flag` and `irq` are 0 and `count` is FFh.
- R2: A valid feed is a write of A5h to address 2 followed directly by a write of 5Ah to address 3. On the next tick of the selected counting clock, `count` takes the staged reload value (written at address 1) and the shadow control takes the staged control (address 0).
- R3: Writing the reload register without a valid feed leaves `count` unaffected.
- R4: In interval mode (control bit 4 = 0), the shadow control copies the staging control every bus-clock cycle with no feed. For example, clearing the run bit (control bit 5) stops the counter.
- R5: With the run bit set, `count` decrements once every 2^(PRE+1) ticks, where PRE is control bits 2:0. The prescaler restarts at every valid feed and every load.
- R6: In interval mode, a decrement from 0 sets `tmo_flag`. `irq` equals `tmo_flag` gated by the interrupt-enable bit (control bit 6).
- R7: `tmo_flag` is cleared only by a control write whose bit 7 is 0. A control write with bit 7 set leaves it unchanged.
- R8: In reset mode (control bit 4 = 1), a decrement from 0 raises `rst_req`, which stays high until `rst_n`. `tmo_flag` is not set.
- R9: In reset mode, writes to the staging control do not reach the shadow until a valid feed.
- R10: In reset mode, any write other than 5Ah to address 3 that directly follows A5h at address 2 raises `rst_req` on the next edge.
- R11: With control bit 3 = 0, the counting clock is the bus clock divided by 32. With bit 3 = 1, it is the `osc_tick` input.
- R12: In interval mode, a key sequence with a wrong second write neither reloads the counter nor requests a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per period of the dedicated oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 first key, 3 second key |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | Sticky system-reset request |
| tmo_flag | output | 1 | Interval timeout flag |
| irq | output | 1 | Interrupt request |
| count | output | 8 | Live down-counter value |

## Verification
The hardest situation to reach is the gap between a completed feed and the load. In that gap the new staging values wait for the next tick of the clock source that is still selected.

The bench holds `osc_tick` low while it writes and feeds. It then releases exactly one tick, so the load cycle and every subsequent prescaler step can be counted precisely. Reset-mode cases are reached by first writing the mode bit in interval mode, where it copies through by itself. Only after that does the bench test that later control writes are blocked and that a broken key sequence raises a reset.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DW = 8,
  parameter int PRE_W = 3,
  parameter int PDIV_W = 5,
  parameter logic [7:0] KEY_A = 8'hA5,
  parameter logic [7:0] KEY_B = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          rst_req,
  output logic          tmo_flag,
  output logic          irq,
  output logic [DW-1:0] count
);
  localparam int SEL_B  = PRE_W;
  localparam int MODE_B = PRE_W + 1;
  localparam int RUN_B  = PRE_W + 2;
  localparam int IEN_B  = PRE_W + 3;
  localparam int FLG_B  = PRE_W + 4;
  localparam int CTL_W  = PRE_W + 4;
  localparam int PS_W   = 1 << PRE_W;
  localparam logic [1:0] A_CTL = 2'd0, A_REL = 2'd1, A_KA = 2'd2, A_KB = 2'd3;

  logic [CTL_W-1:0]  ctl_stg, ctl_sh;
  logic [DW-1:0]     rel_stg;
  logic              armed, pend;
  logic [PDIV_W-1:0] pdiv;
  logic [PS_W-1:0]   presc;

  wire wd_mode   = ctl_sh[MODE_B];
  wire wtick     = ctl_sh[SEL_B] ? osc_tick : (&pdiv);
  wire load      = pend && wtick;
  wire [PS_W-1:0] ps_lim = {PS_W{1'b1}} >> (~ctl_sh[PRE_W-1:0]);
  wire step      = wtick && !pend && ctl_sh[RUN_B] && (presc == ps_lim);
  wire uflow     = step && (count == '0);
  wire wr_ctl    = wr_en && (wr_addr == A_CTL);
  wire good_feed = armed && wr_en && (wr_addr == A_KB) && (wr_data == KEY_B);
  wire bad_feed  = armed && wr_en && !good_feed;

  assign irq = tmo_flag && ctl_sh[IEN_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_stg <= '0;
      rel_stg <= '1;
      armed   <= 1'b0;
      pend    <= 1'b0;
      pdiv    <= '0;
    end else begin
      pdiv <= pdiv + 1'b1;
      if (wr_ctl) ctl_stg <= wr_data[CTL_W-1:0];
      if (wr_en && wr_addr == A_REL) rel_stg <= wr_data[DW-1:0];
      if (wr_en) armed <= (wr_addr == A_KA) && (wr_data == KEY_A);
      pend <= good_feed || (pend && !wtick);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_sh <= '0;
      count  <= '1;
      presc  <= '0;
    end else begin
      if (load || !wd_mode) ctl_sh <= ctl_stg;
      if (load) count <= rel_stg;
      else if (step) count <= count - 1'b1;
      if (good_feed || load) presc <= '0;
      else if (wtick && ctl_sh[RUN_B]) presc <= (presc == ps_lim) ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (uflow && !wd_mode) tmo_flag <= 1'b1;
      else if (wr_ctl && !wr_data[FLG_B]) tmo_flag <= 1'b0;
      if (wd_mode && (uflow || bad_feed)) rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          rst_req,
  input logic          tmo_flag,
  input logic          irq,
  input logic [DW-1:0] count,
  input logic [DW-1:0] rel_stg,
  input logic          armed,
  input logic          pend,
  input logic          wtick,
  input logic          wd_mode
);
  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tmo_flag);
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !(wr_en && wr_addr == 2'd0 && !wr_data[7]) |=> tmo_flag);
  p_load_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend && wtick |=> count == $past(rel_stg));
  p_bad_feed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wd_mode && wr_en && !(wr_addr == 2'd3 && wr_data == 8'h5A) |=> rst_req);
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wtick |=> $stable(count));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rst_req(rst_req), .tmo_flag(tmo_flag), .irq(irq), .count(count),
  .rel_stg(rel_stg), .armed(armed), .pend(pend), .wtick(wtick), .wd_mode(wd_mode)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {irq_en, pre[2:0], reload[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'd3}, {1'b0, 3'd1, 8'd2}, {1'b1, 3'd2, 8'd0},
    {1'b0, 3'd3, 8'd1}, {1'b1, 3'd0, 8'd0}, {1'b1, 3'd2, 8'd5}};
  localparam logic [7:0] SEL = 8'h08, MODE = 8'h10, RUN = 8'h20, IEN = 8'h40, FLG = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rst_req, tmo_flag, irq;
  logic [7:0] count;
  int runs = 0, fails = 0;

  keyed_watchdog u_dut (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req), .tmo_flag(tmo_flag),
    .irq(irq), .count(count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int ntick;
    logic [7:0] prev;
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rst_req == 0 && tmo_flag == 0 && irq == 0, "R1 outputs", {rst_req, tmo_flag, irq}, 0);
    check(count == 8'hFF, "R1 count", count, 8'hFF);

    // R3 reload without feed has no effect
    wr(2'd1, 8'h10);
    wr(2'd0, RUN | SEL);
    tick(2);
    check(count == 8'hFE, "R3 count keeps decrementing", count, 8'hFE);

    // R4 interval mode: run bit cleared without feed stops counter
    wr(2'd0, SEL);
    tick(4);
    check(count == 8'hFE, "R4 counter stopped", count, 8'hFE);

    // R12 wrong second key in interval mode
    wr(2'd2, 8'hA5); wr(2'd3, 8'h00);
    tick(1);
    check(count == 8'hFE, "R12 no reload", count, 8'hFE);
    check(rst_req == 0, "R12 no reset", rst_req, 0);

    // Table: R2 load, R5 prescale, R6 flag/irq
    for (int v = 0; v < NV; v++) begin
      logic ien;
      logic [2:0] pre;
      logic [7:0] rel;
      {ien, pre, rel} = VEC[v];
      wr(2'd0, RUN | SEL | (ien ? IEN : 8'h00) | {5'd0, pre});
      wr(2'd1, rel);
      feed();
      tick(1);
      check(count == rel, "R2 load on tick", count, rel);
      ntick = (int'(rel) + 1) << (int'(pre) + 1);
      tick(ntick - 1);
      check(tmo_flag == 0, "R5 not yet timed out", tmo_flag, 0);
      tick(1);
      check(tmo_flag == 1, "R5 R6 timeout flag", tmo_flag, 1);
      check(irq == ien, "R6 irq gating", irq, ien);
    end

    // R7 flag clear semantics (last vector left flag set, ien=1)
    wr(2'd0, FLG | IEN | SEL);
    check(tmo_flag == 1, "R7 write of one keeps flag", tmo_flag, 1);
    wr(2'd0, IEN | SEL);
    check(tmo_flag == 0 && irq == 0, "R7 write of zero clears", tmo_flag, 0);

    // R8 reset-mode underflow
    do_reset();
    wr(2'd1, 8'd1);
    wr(2'd0, MODE | RUN | SEL);
    feed();
    tick(1);
    check(count == 8'd1, "R8 loaded", count, 1);
    tick(3);
    check(rst_req == 0, "R8 before underflow", rst_req, 0);
    tick(1);
    check(rst_req == 1, "R8 reset request", rst_req, 1);
    check(tmo_flag == 0, "R8 no flag in reset mode", tmo_flag, 0);
    tick(2);
    check(rst_req == 1, "R8 sticky", rst_req, 1);

    // R9 control blocked in reset mode until feed
    do_reset();
    wr(2'd1, 8'd5);
    wr(2'd0, MODE | RUN | SEL);
    feed();
    tick(1);
    wr(2'd0, MODE | SEL);
    tick(2);
    check(count == 8'd4, "R9 still running", count, 4);
    feed();
    tick(1);
    check(count == 8'd5, "R9 R2 reload after feed", count, 5);
    tick(2);
    check(count == 8'd5, "R9 stop applied by feed", count, 5);

    // R10 broken key in reset mode
    check(rst_req == 0, "R10 before", rst_req, 0);
    wr(2'd2, 8'hA5);
    wr(2'd1, 8'h33);
    check(rst_req == 1, "R10 bad feed reset", rst_req, 1);

    // R11 bus clock / 32 source
    do_reset();
    wr(2'd0, RUN);
    prev = count; n = 0;
    while (count == prev && n < 300) begin @(negedge clk); n++; end
    prev = count; n = 0;
    while (count == prev && n < 300) begin @(negedge clk); n++; end
    check(n == 64, "R11 step period", n, 64);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule